// File: doc/BRIEF.md
# Serial-Memory Controller Interrupt Status Block

This block holds the status flags and the interrupt logic of a serial-memory controller. Event sources elsewhere in the controller drive one-cycle pulses, and these set sticky flags. Three steady conditions are shown as live level bits that follow their sources. Software reads the status word over a small register port. That read returns the flags and clears every sticky flag in the same step, so events left over from an earlier command are dropped before a new one starts.

Interrupt enables are never written directly. A write to the enable-set offset turns on each enable bit written as 1. A write to the enable-clear offset turns off each enable bit written as 1. Bits written as 0 leave the enables as they are. A read-only offset shows the current enable set. A single interrupt line is active while any status bit and its enable bit are both 1. A separate output reports command completion. It needs both the instruction-end flag and the chip-select-rise flag, which may arrive in different cycles and add up until the next status read.

Top module: `qsr_irq_ctrl`

## Requirements
- R1: A pulse on an event input sets its status bit one clock later. The bits are receive-full at 0, transmitter-idle at 2, overrun at 3, chip-select-rise at 8 and instruction-end at 10. The bit stays set until a status read.
- R2: Status bits 1 (transmit ready), 9 (chip-select active) and 24 (controller enabled) show their level inputs as sampled at the previous clock edge. A status read does not clear them.
- R3: A read at offset 0x10 returns the status word on bus_rdata one clock after the read strobe. The same read clears all event bits.
- R4: If an event pulse arrives in the same cycle as a status read, that read does not return the event, but the event's bit stays set after the read.
- R5: A write at offset 0x14 sets each enable bit whose data bit is 1. Data bits that are 0 do not change the enables.
- R6: A write at offset 0x18 clears each enable bit whose data bit is 1. Data bits that are 0 do not change the enables.
- R7: A read at offset 0x1C returns the enable set. Only the eight status bit positions can hold a 1. Writes to 0x1C or to 0x10 change no state.
- R8: irq is 1 exactly when some status bit and the same enable bit are both 1.
- R9: cmd_done is 1 while the instruction-end and chip-select-rise flags are both set, even when they were set by separate pulses. A status read drops it.
- R10: After reset all enables are 0, all event flags are 0, and irq, cmd_done and bus_rdata are 0.
- R11: A read at any other offset returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| evt_rx_full | input | 1 | Receive-full event pulse |
| evt_tx_idle | input | 1 | Transmitter-idle event pulse |
| evt_overrun | input | 1 | Overrun event pulse |
| evt_cs_rise | input | 1 | Chip-select-rise event pulse |
| evt_instr_end | input | 1 | Instruction-end event pulse |
| lvl_tx_ready | input | 1 | Transmit-ready level |
| lvl_cs_active | input | 1 | Chip-select-active level |
| lvl_enabled | input | 1 | Controller-enabled level |
| irq | output | 1 | Interrupt request |
| cmd_done | output | 1 | Both completion flags pending |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that every input is steady around the rising edge. The bench keeps to this by driving every input on the falling edge, issuing one bus operation at a time, and holding the level inputs steady for at least one cycle before any status read that checks them. Events and reads are deliberately made to coincide only in the R4 case, and that is the case the flag bank's clear-versus-set assertion covers.

// File: rtl/qsr_pkg.sv
package qsr_pkg;

    localparam int EV_N = 5;
    localparam int LV_N = 3;

    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_SET  = 8'h14;
    localparam logic [7:0] OFS_CLR  = 8'h18;
    localparam logic [7:0] OFS_MASK = 8'h1C;

    // event index -> status bit
    function automatic int ev_pos(input int i);
        case (i)
            0:       return 0;   // receive full
            1:       return 2;   // transmitter idle
            2:       return 3;   // overrun
            3:       return 8;   // chip-select rise
            default: return 10;  // instruction end
        endcase
    endfunction

    // level index -> status bit
    function automatic int lv_pos(input int i);
        case (i)
            0:       return 1;   // transmit ready
            1:       return 9;   // chip-select active
            default: return 24;  // controller enabled
        endcase
    endfunction

    localparam int EV_CSR = 3;
    localparam int EV_IE  = 4;

    typedef struct packed {
        logic [EV_N-1:0] ev;
        logic [LV_N-1:0] lv;
    } flag_state_t;

endpackage

// File: rtl/qsr_flags.sv
module qsr_flags
    import qsr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_N-1:0]   evt,
    input  logic [LV_N-1:0]   lvl,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] status,
    output logic              both_done
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ev = (st_q.ev & ~{EV_N{rd_clr}}) | evt;
        st_d.lv = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status = '0;
        for (int i = 0; i < EV_N; i++) status[ev_pos(i)] = st_q.ev[i];
        for (int j = 0; j < LV_N; j++) status[lv_pos(j)] = st_q.lv[j];
    end

    assign both_done = st_q.ev[EV_CSR] & st_q.ev[EV_IE];

    for (genvar g = 0; g < EV_N; g++) begin : g_ev_chk
        assert_event_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> status[ev_pos(g)]);
        // R4: an event racing a clear survives
        assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && rd_clr) |=> status[ev_pos(g)]);
    end

    for (genvar h = 0; h < LV_N; h++) begin : g_lv_chk
        assert_level_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (status[lv_pos(h)] == $past(lvl[h])));
    end

    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt == '0) |=> (st_q.ev == '0));

endmodule

// File: rtl/qsr_mask.sv
module qsr_mask #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] IMPL   = 32'h0100_070F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);
    localparam logic [DATA_W-1:0] IMPL_W = DATA_W'(IMPL);

    logic [DATA_W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (set_wr) mask_d = mask_d | (wdata & IMPL_W);
        if (clr_wr) mask_d = mask_d & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

    assert_set_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !clr_wr) |=> ((mask_q & $past(wdata & IMPL_W)) == $past(wdata & IMPL_W)));
    assert_clr_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_wr) |=> ((mask_q & $past(wdata)) == '0));
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(mask_q));
    assert_impl_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask_q & ~IMPL_W) == '0));

endmodule

// File: rtl/qsr_irq_ctrl.sv
module qsr_irq_ctrl
    import qsr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_rx_full,
    input  logic              evt_tx_idle,
    input  logic              evt_overrun,
    input  logic              evt_cs_rise,
    input  logic              evt_instr_end,
    input  logic              lvl_tx_ready,
    input  logic              lvl_cs_active,
    input  logic              lvl_enabled,
    output logic              irq,
    output logic              cmd_done
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    logic [EV_N-1:0]   evt_vec;
    logic [LV_N-1:0]   lvl_vec;
    logic [DATA_W-1:0] status, mask;
    logic              rd_stat, wr_set, wr_clr;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    assign evt_vec = {evt_instr_end, evt_cs_rise, evt_overrun, evt_tx_idle, evt_rx_full};
    assign lvl_vec = {lvl_enabled, lvl_cs_active, lvl_tx_ready};

    assign rd_stat = bus_rd && (bus_addr == A_STAT);
    assign wr_set  = bus_wr && (bus_addr == A_SET);
    assign wr_clr  = bus_wr && (bus_addr == A_CLR);

    qsr_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_vec),
        .lvl       (lvl_vec),
        .rd_clr    (rd_stat),
        .status    (status),
        .both_done (cmd_done)
    );

    qsr_mask #(.DATA_W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (wr_set),
        .clr_wr (wr_clr),
        .wdata  (bus_wdata),
        .mask   (mask)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            case (bus_addr)
                A_STAT:  rdata_d = status;
                A_MASK:  rdata_d = mask;
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(status & mask);

    assert_done_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !evt_cs_rise && !evt_instr_end) |=> !cmd_done);
    assert_status_returned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (bus_rdata == $past(status)));
    assert_no_enable_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

// File: tb/tb_qsr_irq_ctrl.sv
module tb_qsr_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  ev = '0;
    logic [2:0]  lv = '0;
    logic        irq, cmd_done;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    qsr_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_rx_full(ev[0]), .evt_tx_idle(ev[1]), .evt_overrun(ev[2]),
        .evt_cs_rise(ev[3]), .evt_instr_end(ev[4]),
        .lvl_tx_ready(lv[0]), .lvl_cs_active(lv[1]), .lvl_enabled(lv[2]),
        .irq(irq), .cmd_done(cmd_done)
    );

    function automatic int epos(input int i);
        case (i) 0: return 0; 1: return 2; 2: return 3; 3: return 8; default: return 10; endcase
    endfunction
    function automatic int lpos(input int i);
        case (i) 0: return 1; 1: return 9; default: return 24; endcase
    endfunction
    function automatic logic [31:0] lvword(input logic [2:0] l);
        return (32'(l[0]) << 1) | (32'(l[1]) << 9) | (32'(l[2]) << 24);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk); ev = e;
        @(negedge clk); ev = '0;
    endtask

    logic [31:0] d;
    logic [31:0] exp_mask;
    localparam logic [31:0] IMPL = 32'h0100_070F;

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 irq", 32'(irq), 0);
        check("R10 cmd_done", 32'(cmd_done), 0);
        check("R10 rdata", bus_rdata, 0);
        rd(8'h1C, d); check("R10 mask", d, 0);
        rd(8'h10, d); check("R10 status", d, 0);

        // R1 / R3: each event sets its bit, a read clears it
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i));
            rd(8'h10, d); check("R1 event bit", d, 32'(1) << epos(i));
            rd(8'h10, d); check("R3 cleared", d, 0);
        end
        // all events together
        pulse(5'h1F);
        rd(8'h10, d); check("R1 all events", d, 32'h0000_050D);
        rd(8'h10, d); check("R3 all cleared", d, 0);

        // R2: levels follow and survive reads
        for (int p = 0; p < 8; p++) begin
            @(negedge clk); lv = 3'(p);
            @(negedge clk);
            rd(8'h10, d); check("R2 level first read", d, lvword(3'(p)));
            rd(8'h10, d); check("R2 level second read", d, lvword(3'(p)));
        end
        @(negedge clk); lv = '0; @(negedge clk);

        // R4: event coincident with the read
        pulse(5'b00001);
        @(negedge clk); bus_addr = 8'h10; bus_rd = 1'b1; ev = 5'b10000;
        @(negedge clk); bus_rd = 1'b0; ev = '0; d = bus_rdata;
        check("R4 read excludes racing event", d, 32'h1);
        rd(8'h10, d); check("R4 racing event kept", d, 32'h400);
        rd(8'h10, d); check("R4 then cleared", d, 0);

        // R5 set sweep
        exp_mask = '0;
        for (int b = 0; b < 32; b++) begin
            wr(8'h14, 32'(1) << b);
            exp_mask = exp_mask | ((32'(1) << b) & IMPL);
            rd(8'h1C, d); check("R5 set bit", d, exp_mask);
        end
        wr(8'h14, 0); rd(8'h1C, d); check("R5 zero write no effect", d, IMPL);
        // R7 read-only and status write ignored
        wr(8'h1C, 32'h0); rd(8'h1C, d); check("R7 mask write ignored", d, IMPL);
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); check("R7 status write ignored", d, 0);
        // R11 other offsets
        rd(8'h00, d); check("R11 offset 0x00", d, 0);
        rd(8'h04, d); check("R11 offset 0x04", d, 0);
        rd(8'h20, d); check("R11 offset 0x20", d, 0);
        // R6 clear sweep
        wr(8'h18, 0); rd(8'h1C, d); check("R6 zero write no effect", d, IMPL);
        for (int b = 0; b < 32; b++) begin
            wr(8'h18, 32'(1) << b);
            exp_mask = exp_mask & ~(32'(1) << b);
            rd(8'h1C, d); check("R6 clear bit", d, exp_mask);
        end

        // R8: single enable vs single event
        for (int k = 0; k < 5; k++) begin
            wr(8'h18, 32'hFFFF_FFFF);
            wr(8'h14, 32'(1) << epos(k));
            for (int i = 0; i < 5; i++) begin
                pulse(5'(1 << i));
                check("R8 irq match", 32'(irq), 32'(i == k));
                rd(8'h10, d);
                check("R8 irq after clear", 32'(irq), 0);
            end
        end
        // R8 level source
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h14, 32'h0100_0000);
        @(negedge clk); lv = 3'b100; @(negedge clk);
        check("R8 level irq", 32'(irq), 1);
        rd(8'h10, d); check("R8 level irq kept after read", 32'(irq), 1);
        wr(8'h18, 32'h0100_0000);
        check("R8 irq off after disable", 32'(irq), 0);
        @(negedge clk); lv = '0; @(negedge clk);

        // R9: completion accumulates
        wr(8'h14, 32'h0000_0500);
        pulse(5'b10000);
        check("R9 one flag only", 32'(cmd_done), 0);
        check("R9 irq on first flag", 32'(irq), 1);
        repeat (3) @(negedge clk);
        pulse(5'b01000);
        check("R9 both flags", 32'(cmd_done), 1);
        rd(8'h10, d); check("R9 status both", d, 32'h0000_0500);
        check("R9 dropped by read", 32'(cmd_done), 0);
        pulse(5'b11000);
        check("R9 same-cycle pair", 32'(cmd_done), 1);
        rd(8'h10, d);
        check("R9 irq cleared", 32'(irq), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule